// File: doc/BRIEF.md
# Management Register Bit-Attribute Bank

This block is the register side of a PHY-style management space: four 16-bit registers reached through a plain port with a shared address, a write strobe with write data, and a read strobe with registered read data. Every bit carries one access attribute, fixed when the block is built. The attributes are read/write, read-only, write-only, write-one-to-clear, write-anything-to-clear, read-to-clear, latch-high, latch-low, self-clearing and reserved. Per-bit hardware inputs (`hw_in`) feed status, event and latch causes. The current value of every bit appears on `ctrl_out`, so writable bits act as controls. Serial management framing sits outside the block.

A read presents the register on `rd_data` one clock after `rd_en` and holds it until the next read. Any clear caused by that read takes effect at the same edge. Each latch-high or latch-low bit runs its own three-state machine. `LT_IDLE` means the bit is clear. `LT_HELD` means it is set and not yet read. `LT_SEEN` means it is set, has been read, and its cause is still present. The transitions are: `LT_IDLE`→`LT_HELD` when the cause is seen. `LT_HELD`→`LT_SEEN` on a read while the cause is present. `LT_HELD`→`LT_IDLE` on a read without the cause. `LT_SEEN`→`LT_IDLE` when the cause goes away. Software reset returns every state to `LT_IDLE`. A latch-low bit uses the inverted input as its cause and reads back the inverse of the latch.

Bit map (register address: bits = attribute, reset value):
- Register 0: bits 3:0 = read/write, reset 0x5. Bits 5:4 = self-clearing. Bits 7:6 = write-only. Bits 11:8 = read/write and kept through software reset, reset 0. Bits 15:12 = reserved.
- Register 1: bits 3:0 = read-only. Bits 7:4 = latch-high. Bits 11:8 = latch-low. Bits 15:12 = read-to-clear.
- Register 2: bits 7:0 = write-one-to-clear. Bits 15:8 = write-anything-to-clear.
- Register 3: bits 7:0 = read/write and kept through software reset, reset 0x3C. Bits 15:8 = reserved.

Bit b of register r uses `hw_in[16*r+b]` and drives `ctrl_out[16*r+b]`.

Top module: `mgmt_reg_bank`

## Requirements
- R1: A read/write bit takes the written value. A read of its register returns that value on `rd_data` in the cycle after `rd_en`. After hard reset, register 0 reads 0x0005.
- R2: A read-only bit (register 1, bits 3:0) reads the live `hw_in` value, and writes to it have no effect.
- R3: A write-only bit (register 0, bits 7:6) stores the written value on `ctrl_out` and always reads as 0.
- R4: A write-one-to-clear bit (register 2, bits 7:0) is set by its `hw_in` bit. Writing 1 clears it and writing 0 leaves it set.
- R5: A write-anything-to-clear bit (register 2, bits 15:8) is set by its `hw_in` bit. Any write to register 2 clears it, whatever the data. A read does not clear it.
- R6: A read-to-clear bit (register 1, bits 15:12) is set by its `hw_in` bit and reads 1 once, then 0 after that read. Writes do not change it.
- R7: A latch-high bit (register 1, bits 7:4) stays 1 after its cause ends until it is read. After a read it stays 1 while the cause is present and drops once the cause ends.
- R8: A latch-low bit (register 1, bits 11:8) reads 0 after its `hw_in` bit has been low, even if the input is high again, until a read. It then follows the input.
- R9: A self-clearing bit (register 0, bits 5:4) is 1 on `ctrl_out` for exactly one clock after a write of 1, then 0. Writing 0 leaves it 0.
- R10: A one-cycle `sw_rst` returns every bit to its reset value, except register 0 bits 11:8 and register 3 bits 7:0, which keep their values.
- R11: Hard reset (`rst_n` low) restores every bit, including the bits kept through software reset. After it, register 3 reads 0x003C.
- R12: Reserved bits (register 0 bits 15:12, register 3 bits 15:8) ignore writes and read as 0.
- R13: When a setting input arrives in the same cycle as a clearing read or write, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| sw_rst | input | 1 | Synchronous software reset, one-cycle pulse |
| addr | input | 2 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| hw_in | input | 64 | Per-bit hardware status, event and latch-cause inputs |
| ctrl_out | output | 64 | Current value of every bit |

## Verification
The assertions assume that `sw_rst` does not coincide with a write that matters. The properties that check bits kept through software reset therefore require that no write happens in the same cycle. The bench raises `sw_rst` only while the strobes are idle. The assertions also assume that every `hw_in` change is sampled cleanly at a clock edge. The bench drives all inputs, `hw_in` included, on the falling edge. It holds each latch cause for whole cycles, so cause and read overlap only in the cycles the event-wins cases intend.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int DW = 16;

    typedef enum logic [3:0] {
        A_RW, A_RO, A_WO, A_W1C, A_WAC, A_RC, A_LH, A_LL, A_SC, A_RSV
    } attr_e;

    function automatic attr_e attr_of(input int r, input int b);
        attr_e a;
        a = A_RSV;
        case (r)
            0: begin
                if (b < 4)       a = A_RW;
                else if (b < 6)  a = A_SC;
                else if (b < 8)  a = A_WO;
                else if (b < 12) a = A_RW;
                else             a = A_RSV;
            end
            1: begin
                if (b < 4)       a = A_RO;
                else if (b < 8)  a = A_LH;
                else if (b < 12) a = A_LL;
                else             a = A_RC;
            end
            2: a = (b < 8) ? A_W1C : A_WAC;
            3: a = (b < 8) ? A_RW : A_RSV;
            default: a = A_RSV;
        endcase
        return a;
    endfunction

    function automatic logic dflt_of(input int r, input int b);
        if (r == 0) return (b == 0) || (b == 2);
        if (r == 3) return (b >= 2) && (b <= 5);
        return 1'b0;
    endfunction

    function automatic logic keep_of(input int r, input int b);
        if (r == 0) return (b >= 8) && (b < 12);
        if (r == 3) return (b < 8);
        return 1'b0;
    endfunction

endpackage

// File: rtl/mgmt_latch_fsm.sv
module mgmt_latch_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic cause,
    input  logic rd_hit,
    output logic set_o
);
    typedef enum logic [1:0] {LT_IDLE, LT_HELD, LT_SEEN} lt_state_e;

    lt_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      st <= LT_IDLE;
        else if (sw_rst) st <= LT_IDLE;
        else             st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            LT_IDLE: if (cause) st_nx = LT_HELD;
            LT_HELD: if (rd_hit) st_nx = cause ? LT_SEEN : LT_IDLE;
            LT_SEEN: if (!cause) st_nx = LT_IDLE;
            default: st_nx = LT_IDLE;
        endcase
    end

    always_comb set_o = (st != LT_IDLE);

    p_lh_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LT_HELD && !rd_hit && !sw_rst) |=> set_o);
    p_lh_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LT_SEEN && !cause && !sw_rst) |=> !set_o);
    p_lh_event_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cause && !sw_rst) |=> set_o);
endmodule

// File: rtl/mgmt_bit_cell.sv
module mgmt_bit_cell #(
    parameter regbank_pkg::attr_e ATTR = regbank_pkg::A_RSV,
    parameter logic DFLT = 1'b0,
    parameter logic KEEP = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic rd_hit,
    input  logic hw_bit,
    output logic q,
    output logic rd_val
);
    import regbank_pkg::*;

    logic unused_in;
    assign unused_in = ^{clk, rst_n, sw_rst, wr_hit, wr_bit, rd_hit, hw_bit};

    if (ATTR == A_RSV) begin : g_rsv
        assign q = 1'b0;
    end else if (ATTR == A_RO) begin : g_ro
        assign q = hw_bit;
    end else if (ATTR == A_LH || ATTR == A_LL) begin : g_latch
        logic lat;
        mgmt_latch_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_rst (sw_rst),
            .cause  ((ATTR == A_LL) ? ~hw_bit : hw_bit),
            .rd_hit (rd_hit),
            .set_o  (lat)
        );
        assign q = (ATTR == A_LL) ? ~lat : lat;
    end else begin : g_store
        logic q_r, q_nx;

        always_comb begin
            q_nx = q_r;
            unique case (ATTR)
                A_RW, A_WO: if (wr_hit) q_nx = wr_bit;
                A_SC:       q_nx = wr_hit & wr_bit;
                A_W1C:      q_nx = hw_bit | (q_r & ~(wr_hit & wr_bit));
                A_WAC:      q_nx = hw_bit | (q_r & ~wr_hit);
                A_RC:       q_nx = hw_bit | (q_r & ~rd_hit);
                default:    q_nx = q_r;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               q_r <= DFLT;
            else if (sw_rst && !KEEP) q_r <= DFLT;
            else                      q_r <= q_nx;
        end

        assign q = q_r;

        if (KEEP) begin : g_keep_chk
            p_keep_swrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (sw_rst && !wr_hit) |=> $stable(q_r));
        end else begin : g_dflt_chk
            p_swrst_dflt_r10: assert property (@(posedge clk) disable iff (!rst_n)
                sw_rst |=> (q_r == DFLT));
        end

        if (ATTR == A_SC) begin : g_sc_chk
            p_sc_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (q_r && !(wr_hit && wr_bit)) |=> !q_r);
        end
        if (ATTR == A_W1C) begin : g_w1c_chk
            p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_hit && wr_bit && !hw_bit && !sw_rst) |=> !q_r);
        end
        if (ATTR == A_RC) begin : g_rc_chk
            p_rc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_hit && !hw_bit && !sw_rst) |=> !q_r);
        end
        if (ATTR == A_W1C || ATTR == A_WAC || ATTR == A_RC) begin : g_ev_chk
            p_event_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_bit && !sw_rst) |=> q_r);
        end
    end

    assign rd_val = (ATTR == A_WO || ATTR == A_RSV) ? 1'b0 : q;
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank #(
    parameter int NREGS = 4,
    localparam int DW = regbank_pkg::DW,
    localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_rst,
    input  logic [AW-1:0]       addr,
    input  logic                wr_en,
    input  logic [DW-1:0]       wr_data,
    input  logic                rd_en,
    output logic [DW-1:0]       rd_data,
    input  logic [NREGS*DW-1:0] hw_in,
    output logic [NREGS*DW-1:0] ctrl_out
);
    import regbank_pkg::*;

    logic [DW-1:0] rd_vec [NREGS];
    logic [DW-1:0] rd_sel;

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        localparam logic [AW-1:0] RA = AW'(r);
        logic wr_hit, rd_hit;
        assign wr_hit = wr_en && (addr == RA);
        assign rd_hit = rd_en && (addr == RA);
        for (genvar b = 0; b < DW; b++) begin : g_bit
            mgmt_bit_cell #(
                .ATTR (attr_of(r, b)),
                .DFLT (dflt_of(r, b)),
                .KEEP (keep_of(r, b))
            ) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .sw_rst (sw_rst),
                .wr_hit (wr_hit),
                .wr_bit (wr_data[b]),
                .rd_hit (rd_hit),
                .hw_bit (hw_in[r*DW+b]),
                .q      (ctrl_out[r*DW+b]),
                .rd_val (rd_vec[r][b])
            );
        end
    end

    always_comb begin
        rd_sel = '0;
        for (int r = 0; r < NREGS; r++)
            if (addr == AW'(r)) rd_sel = rd_vec[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_sel;
    end

    p_rsv_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(0)) |=> (rd_data[15:12] == 4'h0));
    p_wo_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(0)) |=> (rd_data[7:6] == 2'b00));
    p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/mgmt_reg_bank_test.sv
module mgmt_reg_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [63:0] hw_in = 64'h0000_0000_0F00_0000;
    logic [63:0] ctrl_out;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mgmt_reg_bank uut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .hw_in(hw_in), .ctrl_out(ctrl_out)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic hw_pulse(input int idx);
        @(negedge clk); hw_in[idx] = ~hw_in[idx];
        @(negedge clk); hw_in[idx] = ~hw_in[idx];
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(2'd0, d); check("R1 reset reg0", d, 16'h0005);
        rd(2'd3, d); check("R11 reset reg3", d, 16'h003C);
        rd(2'd1, d); check("R8 reset reg1", d, 16'h0F00);
    endtask

    task automatic t_rw_wo_sc;
        logic [15:0] d;
        wr(2'd0, 16'hFFFF);
        check("R9 sc pulse high", {14'd0, ctrl_out[5:4]}, 16'h0003);
        check("R3 wo on ctrl_out", {14'd0, ctrl_out[7:6]}, 16'h0003);
        @(negedge clk);
        check("R9 sc back low", {14'd0, ctrl_out[5:4]}, 16'h0000);
        rd(2'd0, d); check("R1 R3 R12 read reg0", d, 16'h0F0F);
        wr(2'd0, 16'h0F0F);
        check("R9 write zero no pulse", {14'd0, ctrl_out[5:4]}, 16'h0000);
        wr(2'd3, 16'hFF00);
        rd(2'd3, d); check("R12 reserved reg3", d, 16'h0000);
    endtask

    task automatic t_ro;
        logic [15:0] d;
        @(negedge clk); hw_in[19:16] = 4'hA;
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); check("R2 ro live", d & 16'h000F, 16'h000A);
        @(negedge clk); hw_in[19:16] = 4'h3;
        rd(2'd1, d); check("R2 ro follows", d & 16'h000F, 16'h0003);
        hw_in[19:16] = 4'h0;
    endtask

    task automatic t_lh;
        logic [15:0] d;
        hw_pulse(20);
        rd(2'd1, d); check("R7 held after cause gone", d & 16'h00F0, 16'h0010);
        rd(2'd1, d); check("R7 cleared by read", d & 16'h00F0, 16'h0000);
        @(negedge clk); hw_in[21] = 1'b1;
        rd(2'd1, d); check("R7 set with cause", d & 16'h00F0, 16'h0020);
        rd(2'd1, d); check("R7 stays while cause", d & 16'h00F0, 16'h0020);
        hw_in[21] = 1'b0;
        @(negedge clk);
        rd(2'd1, d); check("R7 drops after cause", d & 16'h00F0, 16'h0000);
    endtask

    task automatic t_ll;
        logic [15:0] d;
        hw_pulse(24);
        rd(2'd1, d); check("R8 latched low", d & 16'h0F00, 16'h0E00);
        rd(2'd1, d); check("R8 released", d & 16'h0F00, 16'h0F00);
    endtask

    task automatic t_rc;
        logic [15:0] d;
        hw_pulse(28);
        wr(2'd1, 16'h0000);
        rd(2'd1, d); check("R6 set, write ignored", d & 16'hF000, 16'h1000);
        rd(2'd1, d); check("R6 cleared by read", d & 16'hF000, 16'h0000);
    endtask

    task automatic t_event_wins;
        logic [15:0] d;
        @(negedge clk); hw_in[29] = 1'b1;
        rd(2'd1, d); check("R13 rc read with event", d & 16'hF000, 16'h2000);
        hw_in[29] = 1'b0;
        rd(2'd1, d); check("R13 rc stayed set", d & 16'hF000, 16'h2000);
        rd(2'd1, d); check("R13 rc then clear", d & 16'hF000, 16'h0000);
        @(negedge clk); hw_in[32] = 1'b1;
        wr(2'd2, 16'h0001);
        hw_in[32] = 1'b0;
        rd(2'd2, d); check("R13 w1c write with event", d, 16'h0001);
        wr(2'd2, 16'h0001);
        rd(2'd2, d); check("R4 w1c cleared", d, 16'h0000);
    endtask

    task automatic t_w1c;
        logic [15:0] d;
        @(negedge clk); hw_in[39:32] = 8'hFF;
        @(negedge clk); hw_in[39:32] = 8'h00;
        wr(2'd2, 16'h000F);
        rd(2'd2, d); check("R4 w1c partial", d, 16'h00F0);
        wr(2'd2, 16'h0000);
        rd(2'd2, d); check("R4 write zero keeps", d, 16'h00F0);
        wr(2'd2, 16'h00F0);
        rd(2'd2, d); check("R4 w1c all clear", d, 16'h0000);
    endtask

    task automatic t_wac;
        logic [15:0] d;
        @(negedge clk); hw_in[47:40] = 8'hFF;
        @(negedge clk); hw_in[47:40] = 8'h00;
        rd(2'd2, d); check("R5 wac set", d, 16'hFF00);
        rd(2'd2, d); check("R5 read keeps", d, 16'hFF00);
        wr(2'd2, 16'h0000);
        rd(2'd2, d); check("R5 any write clears", d, 16'h0000);
    endtask

    task automatic t_swrst;
        logic [15:0] d;
        wr(2'd0, 16'h0FFF);
        wr(2'd3, 16'h00AB);
        @(negedge clk); hw_in[33] = 1'b1;
        @(negedge clk); hw_in[33] = 1'b0;
        @(negedge clk); sw_rst = 1'b1;
        @(negedge clk); sw_rst = 1'b0;
        check("R10 wo back to default", {14'd0, ctrl_out[7:6]}, 16'h0000);
        rd(2'd0, d); check("R10 reg0 after sw reset", d, 16'h0F05);
        rd(2'd3, d); check("R10 reg3 kept", d, 16'h00AB);
        rd(2'd2, d); check("R10 events cleared", d, 16'h0000);
    endtask

    task automatic t_hard;
        logic [15:0] d;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        rd(2'd0, d); check("R11 reg0 after hard reset", d, 16'h0005);
        rd(2'd3, d); check("R11 reg3 after hard reset", d, 16'h003C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rw_wo_sc();
        t_ro();
        t_lh();
        t_ll();
        t_rc();
        t_event_wins();
        t_w1c();
        t_wac();
        t_swrst();
        t_hard();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule